// File: doc/BRIEF.md
# Level-Banked Register File With Status

This block holds the general registers and the status word of a 16-bit processor that runs on sixteen program levels. Each level owns a private bank of sixteen 16-bit registers, 256 words in all. The block keeps one working copy, which is the bank of the current level. All register reads and writes go to this copy. The lower half of each bank is open to ordinary program accesses. The upper half can be reached only when the privilege input is high, which is how the microprogram reaches it.

A level change is requested with a target level. The block then spends one cycle writing the working copy back into the bank of the old level. In the next cycle it loads the bank of the new level, and `busy` is high for those two cycles. The status word combines three parts: a shared upper nibble of global control bits, a read-only field that shows the current level, and a lower byte that is banked per level. The lower byte carries a dynamic overflow flag, a sticky static overflow flag, a carry flag and a sticky error flag. The error flag of the current level drives an interrupt output.

Top module: `lvl_regfile`

## Requirements
- R1: After reset, every register of every level reads 0, `sts_word` reads 0, `cur_lvl` is 0 and `busy` is 0.
- R2: With `priv` low, registers 0 to 7 can be written. A written value can be read back on `rd_data` in the cycle after the write edge. Reads are combinational.
- R3: With `priv` low, registers 8 to 15 are refused. A write to them changes nothing and raises `wr_deny` during that cycle, and a read of them returns 0. With `priv` high, all 16 registers can be written and read.
- R4: A level request taken while idle holds `busy` high for exactly two cycles. `cur_lvl` and `sts_word[11:8]` show the new level once `busy` falls. A request made while `busy` is high is ignored.
- R5: Each level keeps its own register contents across switches. A value written on one level reappears when that level becomes current again. A level never entered reads 0.
- R6: While `busy` is high, register reads return 0, and register writes, status writes, flag updates and error events have no effect.
- R7: A status write loads `sts_word[15:12]` and `sts_word[7:0]` from `sts_wdata`. Bits 11:8 always show the current level and ignore the written data.
- R8: `sts_word[15:12]` is shared by all levels and survives level switches. `sts_word[7:0]` is stored separately for each level.
- R9: A flag update sets bit 0 (dynamic overflow) to `flg_ovf` and bit 2 (carry) to `flg_carry`, taken from that update alone.
- R10: Bit 1 (static overflow) is set by any flag update with `flg_ovf` high. Later updates leave it set. Only a status write with bit 1 low clears it.
- R11: `err_set` sets bit 3 (error). It stays set until a status write clears it. `err_irq` equals bit 3 of the current level, so it follows level switches.
- R12: When a status write falls in the same cycle as a flag update or an error event, the written value is taken, but an overflow in that update still sets bit 1 and an error event still sets bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lvl_req_valid | input | 1 | Request a switch to `lvl_req` |
| lvl_req | input | 4 | Target program level |
| busy | output | 1 | Bank swap in progress |
| cur_lvl | output | 4 | Current program level |
| priv | input | 1 | Microprogram privilege for registers 8 to 15 |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| wr_deny | output | 1 | Current write refused for lack of privilege |
| sts_we | input | 1 | Whole status word write |
| sts_wdata | input | 16 | Status write data |
| flg_upd | input | 1 | Flag update from an arithmetic result |
| flg_ovf | input | 1 | Overflow of that result |
| flg_carry | input | 1 | Carry of that result |
| err_set | input | 1 | Error event |
| sts_word | output | 16 | Status word of the current level |
| err_irq | output | 1 | Error flag of the current level |

## Verification
Two status events can land on the same clock edge: a whole-word status write, and a flag update or error event. The bench drives a status write of zero together with an overflow-and-carry update and an error event, all in one cycle. It then expects the written zero for the dynamic overflow and carry bits, with the static overflow and error bits forced to one. A second collision puts register, status and flag activity into the swap window, and the bench checks that none of it appears on the target level or in the shared nibble.

// File: rtl/lvl_regfile_pkg.sv
package lvl_regfile_pkg;

    localparam int STW    = 16;
    localparam int LOB    = 8;
    localparam int LVF    = 4;
    localparam int GLB    = 4;

    localparam int BIT_Q  = 0;
    localparam int BIT_O  = 1;
    localparam int BIT_C  = 2;
    localparam int BIT_Z  = 3;

    typedef enum logic [1:0] {
        SW_IDLE = 2'd0,
        SW_SAVE = 2'd1,
        SW_LOAD = 2'd2
    } swap_st_e;

endpackage

// File: rtl/lvl_swap_ctrl.sv
module lvl_swap_ctrl
    import lvl_regfile_pkg::*;
#(
    parameter int NLVL = 16,
    localparam int LW  = $clog2(NLVL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lvl_req_valid,
    input  logic [LW-1:0] lvl_req,
    output logic          busy,
    output logic          save_en,
    output logic [LW-1:0] save_lvl,
    output logic          load_en,
    output logic [LW-1:0] load_lvl,
    output logic [LW-1:0] cur_lvl
);

    typedef struct packed {
        swap_st_e      st;
        logic [LW-1:0] cur;
        logic [LW-1:0] tgt;
    } ctl_t;

    ctl_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        save_en = 1'b0;
        load_en = 1'b0;
        case (s_q.st)
            SW_IDLE: begin
                if (lvl_req_valid) begin
                    s_d.st  = SW_SAVE;
                    s_d.tgt = lvl_req;
                end
            end
            SW_SAVE: begin
                save_en = 1'b1;
                s_d.st  = SW_LOAD;
            end
            SW_LOAD: begin
                load_en = 1'b1;
                s_d.cur = s_q.tgt;
                s_d.st  = SW_IDLE;
            end
            default: s_d.st = SW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: SW_IDLE, cur: '0, tgt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy     = (s_q.st != SW_IDLE);
    assign cur_lvl  = s_q.cur;
    assign save_lvl = s_q.cur;
    assign load_lvl = s_q.tgt;

    AST_SAVE_THEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        save_en |=> load_en); // R4
    AST_SWAP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (!busy && cur_lvl == $past(load_lvl))); // R4
    AST_BUSY_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load_en) |=> $stable(load_lvl)); // R4

endmodule

// File: rtl/lvl_bank_store.sv
module lvl_bank_store #(
    parameter int NLVL = 16,
    parameter int NREG = 16,
    parameter int W    = 16,
    localparam int LW  = $clog2(NLVL),
    localparam int RW  = NREG * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          save_en,
    input  logic [LW-1:0] save_lvl,
    input  logic [RW-1:0] save_row,
    input  logic [LW-1:0] load_lvl,
    output logic [RW-1:0] load_row
);

    typedef struct packed {
        logic [NLVL-1:0][RW-1:0] rows;
    } bank_t;

    bank_t b_d, b_q;
    logic [NLVL-1:0] hit;

    for (genvar g = 0; g < NLVL; g++) begin : g_hit
        assign hit[g] = save_en && (save_lvl == LW'(g));
    end

    always_comb begin
        b_d = b_q;
        for (int i = 0; i < NLVL; i++) begin
            if (hit[i]) begin
                b_d.rows[i] = save_row;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign load_row = b_q.rows[load_lvl];

    AST_BANK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !save_en |=> $stable(b_q)); // R5
    AST_ONE_ROW_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit)); // R5

endmodule

// File: rtl/lvl_work_regs.sv
module lvl_work_regs #(
    parameter int NREG = 16,
    parameter int NPUB = 8,
    parameter int W    = 16,
    localparam int AW  = $clog2(NREG),
    localparam int RW  = NREG * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  logic          priv,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    output logic          wr_deny,
    input  logic          load_en,
    input  logic [RW-1:0] load_row,
    output logic [RW-1:0] cur_row
);

    typedef struct packed {
        logic [NREG-1:0][W-1:0] regs;
    } work_t;

    work_t w_d, w_q;
    logic  rd_hi, wr_hi, wr_ok;

    function automatic logic is_hi(input logic [AW-1:0] a);
        return {1'b0, a} >= (AW+1)'(NPUB);
    endfunction

    assign rd_hi = is_hi(rd_addr);
    assign wr_hi = is_hi(wr_addr);
    assign wr_ok = wr_en && !busy && (priv || !wr_hi);

    always_comb begin
        w_d = w_q;
        if (load_en) begin
            w_d.regs = load_row;
        end else if (wr_ok) begin
            w_d.regs[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign rd_data = (busy || (!priv && rd_hi)) ? '0 : w_q.regs[rd_addr];
    assign wr_deny = wr_en && !busy && !priv && wr_hi;
    assign cur_row = w_q.regs;

    AST_HI_WRITE_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !priv && is_hi(wr_addr) && !load_en) |=> $stable(w_q)); // R3
    AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load_en) |=> $stable(w_q)); // R6
    AST_LOW_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && !load_en && !is_hi(wr_addr))
        |=> (w_q.regs[$past(wr_addr)] == $past(wr_data))); // R2

endmodule

// File: rtl/lvl_status.sv
module lvl_status
    import lvl_regfile_pkg::*;
#(
    parameter int NLVL = 16,
    localparam int LW  = $clog2(NLVL)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           busy,
    input  logic           sts_we,
    input  logic [STW-1:0] sts_wdata,
    input  logic           flg_upd,
    input  logic           flg_ovf,
    input  logic           flg_carry,
    input  logic           err_set,
    input  logic           save_en,
    input  logic [LW-1:0]  save_lvl,
    input  logic           load_en,
    input  logic [LW-1:0]  load_lvl,
    input  logic [LW-1:0]  cur_lvl,
    output logic [STW-1:0] sts_word,
    output logic           err_irq
);

    typedef struct packed {
        logic [NLVL-1:0][LOB-1:0] bank;
        logic [LOB-1:0]           lo;
        logic [GLB-1:0]           glob;
    } sts_t;

    sts_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (save_en) begin
            s_d.bank[save_lvl] = s_q.lo;
        end
        if (load_en) begin
            s_d.lo = s_q.bank[load_lvl];
        end else if (!busy) begin
            if (sts_we) begin
                s_d.lo   = sts_wdata[LOB-1:0];
                s_d.glob = sts_wdata[STW-1 -: GLB];
            end else if (flg_upd) begin
                s_d.lo[BIT_Q] = flg_ovf;
                s_d.lo[BIT_C] = flg_carry;
            end
            if (flg_upd && flg_ovf) begin
                s_d.lo[BIT_O] = 1'b1;
            end
            if (err_set) begin
                s_d.lo[BIT_Z] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sts_word = {s_q.glob, LVF'(cur_lvl), s_q.lo};
    assign err_irq  = s_q.lo[BIT_Z];

    AST_STATIC_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_word[BIT_O] && !sts_we && !load_en) |=> sts_word[BIT_O]); // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_irq && !sts_we && !load_en) |=> err_irq); // R11
    AST_DYN_OVF_LATEST: assert property (@(posedge clk) disable iff (!rst_n)
        (flg_upd && !sts_we && !busy) |=> (sts_word[BIT_Q] == $past(flg_ovf))); // R9
    AST_WRITE_EVENT_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_we && !busy && flg_upd && flg_ovf) |=> sts_word[BIT_O]); // R12
    AST_GLOBAL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sts_we || busy) |=> $stable(sts_word[STW-1 -: GLB])); // R8

endmodule

// File: rtl/lvl_regfile.sv
module lvl_regfile
    import lvl_regfile_pkg::*;
#(
    parameter int NLVL = 16,
    parameter int NREG = 16,
    parameter int NPUB = 8,
    parameter int W    = 16,
    localparam int LW  = $clog2(NLVL),
    localparam int AW  = $clog2(NREG),
    localparam int RW  = NREG * W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           lvl_req_valid,
    input  logic [LW-1:0]  lvl_req,
    output logic           busy,
    output logic [LW-1:0]  cur_lvl,
    input  logic           priv,
    input  logic [AW-1:0]  rd_addr,
    output logic [W-1:0]   rd_data,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [W-1:0]   wr_data,
    output logic           wr_deny,
    input  logic           sts_we,
    input  logic [STW-1:0] sts_wdata,
    input  logic           flg_upd,
    input  logic           flg_ovf,
    input  logic           flg_carry,
    input  logic           err_set,
    output logic [STW-1:0] sts_word,
    output logic           err_irq
);

    logic          save_en, load_en;
    logic [LW-1:0] save_lvl, load_lvl;
    logic [RW-1:0] cur_row, load_row;

    lvl_swap_ctrl #(.NLVL(NLVL)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .lvl_req_valid (lvl_req_valid),
        .lvl_req       (lvl_req),
        .busy          (busy),
        .save_en       (save_en),
        .save_lvl      (save_lvl),
        .load_en       (load_en),
        .load_lvl      (load_lvl),
        .cur_lvl       (cur_lvl)
    );

    lvl_bank_store #(.NLVL(NLVL), .NREG(NREG), .W(W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .save_en  (save_en),
        .save_lvl (save_lvl),
        .save_row (cur_row),
        .load_lvl (load_lvl),
        .load_row (load_row)
    );

    lvl_work_regs #(.NREG(NREG), .NPUB(NPUB), .W(W)) u_work (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .priv     (priv),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_deny  (wr_deny),
        .load_en  (load_en),
        .load_row (load_row),
        .cur_row  (cur_row)
    );

    lvl_status #(.NLVL(NLVL)) u_sts (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .sts_we    (sts_we),
        .sts_wdata (sts_wdata),
        .flg_upd   (flg_upd),
        .flg_ovf   (flg_ovf),
        .flg_carry (flg_carry),
        .err_set   (err_set),
        .save_en   (save_en),
        .save_lvl  (save_lvl),
        .load_en   (load_en),
        .load_lvl  (load_lvl),
        .cur_lvl   (cur_lvl),
        .sts_word  (sts_word),
        .err_irq   (err_irq)
    );

    AST_LEVEL_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sts_word[11:8] == LVF'(cur_lvl))); // R4

endmodule

// File: tb/lvl_regfile_bench.sv
module lvl_regfile_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lvl_req_valid = 1'b0;
    logic [3:0]  lvl_req = '0;
    logic        busy;
    logic [3:0]  cur_lvl;
    logic        priv = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        wr_deny;
    logic        sts_we = 1'b0;
    logic [15:0] sts_wdata = '0;
    logic        flg_upd = 1'b0;
    logic        flg_ovf = 1'b0;
    logic        flg_carry = 1'b0;
    logic        err_set = 1'b0;
    logic [15:0] sts_word;
    logic        err_irq;

    int vecs = 0;
    int bad  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lvl_regfile u_lvl_regfile (
        .clk (clk), .rst_n (rst_n),
        .lvl_req_valid (lvl_req_valid), .lvl_req (lvl_req),
        .busy (busy), .cur_lvl (cur_lvl), .priv (priv),
        .rd_addr (rd_addr), .rd_data (rd_data),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data), .wr_deny (wr_deny),
        .sts_we (sts_we), .sts_wdata (sts_wdata),
        .flg_upd (flg_upd), .flg_ovf (flg_ovf), .flg_carry (flg_carry),
        .err_set (err_set), .sts_word (sts_word), .err_irq (err_irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        vecs++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, input logic p, output logic [15:0] v);
        rd_addr = a;
        priv    = p;
        #1;
        v       = rd_data;
        priv    = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic p);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; priv = p;
        @(negedge clk);
        wr_en = 1'b0; priv = 1'b0;
    endtask

    task automatic sts_wr(input logic [15:0] d);
        @(negedge clk);
        sts_we = 1'b1; sts_wdata = d;
        @(negedge clk);
        sts_we = 1'b0;
    endtask

    task automatic upd(input logic o, input logic c);
        @(negedge clk);
        flg_upd = 1'b1; flg_ovf = o; flg_carry = c;
        @(negedge clk);
        flg_upd = 1'b0; flg_ovf = 1'b0; flg_carry = 1'b0;
    endtask

    task automatic raise_err();
        @(negedge clk);
        err_set = 1'b1;
        @(negedge clk);
        err_set = 1'b0;
    endtask

    task automatic switch_to(input logic [3:0] l);
        @(negedge clk);
        lvl_req_valid = 1'b1; lvl_req = l;
        @(negedge clk);
        lvl_req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        chk("R1 status", sts_word, 16'h0000);
        chk("R1 busy", {15'd0, busy}, 16'd0);
        chk("R1 level", {12'd0, cur_lvl}, 16'd0);
        rd(4'd2, 1'b1, v);  chk("R1 r2", v, 16'd0);
        rd(4'd13, 1'b1, v); chk("R1 r13", v, 16'd0);
    endtask

    task automatic t_prog_port();
        logic [15:0] v;
        wr(4'd3, 16'hA5C3, 1'b0);
        rd(4'd3, 1'b0, v); chk("R2 r3", v, 16'hA5C3);
        wr(4'd0, 16'h1234, 1'b0);
        rd(4'd0, 1'b0, v); chk("R2 r0", v, 16'h1234);
    endtask

    task automatic t_priv();
        logic [15:0] v;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'd9; wr_data = 16'hBEEF; priv = 1'b0;
        #1;
        chk("R3 deny", {15'd0, wr_deny}, 16'd1);
        @(negedge clk);
        wr_en = 1'b0;
        rd(4'd9, 1'b1, v); chk("R3 r9 unchanged", v, 16'h0000);
        wr(4'd9, 16'hCAFE, 1'b1);
        rd(4'd9, 1'b1, v); chk("R3 r9 priv read", v, 16'hCAFE);
        rd(4'd9, 1'b0, v); chk("R3 r9 plain read", v, 16'h0000);
    endtask

    task automatic t_switch();
        @(negedge clk);
        lvl_req_valid = 1'b1; lvl_req = 4'd5;
        @(negedge clk);
        chk("R4 busy c1", {15'd0, busy}, 16'd1);
        lvl_req = 4'd9;
        @(negedge clk);
        lvl_req_valid = 1'b0;
        chk("R4 busy c2", {15'd0, busy}, 16'd1);
        @(negedge clk);
        chk("R4 busy done", {15'd0, busy}, 16'd0);
        chk("R4 level", {12'd0, cur_lvl}, 16'd5);
        chk("R4 field", {12'd0, sts_word[11:8]}, 16'd5);
        @(negedge clk);
        chk("R4 no second swap", {11'd0, busy, cur_lvl}, 16'd5);
    endtask

    task automatic t_banks();
        logic [15:0] v;
        rd(4'd3, 1'b0, v); chk("R5 fresh r3", v, 16'h0000);
        rd(4'd9, 1'b1, v); chk("R5 fresh r9", v, 16'h0000);
        wr(4'd3, 16'h5555, 1'b0);
        switch_to(4'd0);
        rd(4'd3, 1'b0, v); chk("R5 lvl0 r3", v, 16'hA5C3);
        rd(4'd9, 1'b1, v); chk("R5 lvl0 r9", v, 16'hCAFE);
        switch_to(4'd5);
        rd(4'd3, 1'b0, v); chk("R5 lvl5 r3", v, 16'h5555);
    endtask

    task automatic t_flags();
        upd(1'b1, 1'b1);
        chk("R9 Q C set", sts_word, 16'h0507);
        upd(1'b0, 1'b0);
        chk("R9 Q C from latest", {13'd0, sts_word[2], 1'b0, sts_word[0]}, 16'd0);
        chk("R10 O held", sts_word, 16'h0502);
        sts_wr(16'h0000);
        chk("R10 O cleared", sts_word, 16'h0500);
    endtask

    task automatic t_err();
        raise_err();
        chk("R11 Z set", sts_word, 16'h0508);
        chk("R11 irq", {15'd0, err_irq}, 16'd1);
        upd(1'b0, 1'b1);
        chk("R11 Z sticky", sts_word, 16'h050C);
        switch_to(4'd0);
        chk("R11 irq lvl0", {15'd0, err_irq}, 16'd0);
        switch_to(4'd5);
        chk("R11 irq back", {15'd0, err_irq}, 16'd1);
        sts_wr(16'h0000);
        chk("R11 cleared", {err_irq, sts_word[14:0]}, 16'h0500);
    endtask

    task automatic t_sts_write();
        sts_wr(16'hF0F0);
        chk("R7 write", sts_word, 16'hF5F0);
    endtask

    task automatic t_shared();
        switch_to(4'd0);
        chk("R8 shared nibble lvl0", sts_word, 16'hF000);
        sts_wr(16'h3A6C);
        chk("R8 write lvl0", sts_word, 16'h306C);
        switch_to(4'd5);
        chk("R8 lvl5 banked byte", sts_word, 16'h35F0);
    endtask

    task automatic t_collide();
        @(negedge clk);
        sts_we = 1'b1; sts_wdata = 16'h0000;
        flg_upd = 1'b1; flg_ovf = 1'b1; flg_carry = 1'b1; err_set = 1'b1;
        @(negedge clk);
        sts_we = 1'b0; flg_upd = 1'b0; flg_ovf = 1'b0; flg_carry = 1'b0; err_set = 1'b0;
        chk("R12 merge", sts_word, 16'h050A);
        chk("R12 irq", {15'd0, err_irq}, 16'd1);
    endtask

    task automatic t_busy_block();
        logic [15:0] v;
        @(negedge clk);
        lvl_req_valid = 1'b1; lvl_req = 4'd2;
        @(negedge clk);
        lvl_req_valid = 1'b0;
        sts_we = 1'b1; sts_wdata = 16'hFFFF;
        wr_en = 1'b1; wr_addr = 4'd1; wr_data = 16'h7777;
        flg_upd = 1'b1; flg_ovf = 1'b1; err_set = 1'b1;
        rd(4'd3, 1'b0, v); chk("R6 read while busy", v, 16'h0000);
        @(negedge clk);
        @(negedge clk);
        sts_we = 1'b0; wr_en = 1'b0; flg_upd = 1'b0; flg_ovf = 1'b0; err_set = 1'b0;
        chk("R6 status untouched", sts_word, 16'h0200);
        rd(4'd1, 1'b0, v); chk("R6 lvl2 r1", v, 16'h0000);
        switch_to(4'd5);
        chk("R6 lvl5 status", sts_word, 16'h050A);
        rd(4'd1, 1'b0, v); chk("R6 lvl5 r1", v, 16'h0000);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prog_port();
        t_priv();
        t_switch();
        t_banks();
        t_flags();
        t_err();
        t_sts_write();
        t_shared();
        t_collide();
        t_busy_block();
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

endmodule